// File: doc/BRIEF.md
# Three-Wire Display Link Peripheral

This block is the peripheral end of a synchronous three-wire link between a host controller and a display controller. The host drives a serial clock and a data line toward the block. The block drives one return line back to the host. That line carries response bits during a transfer. Between transfers it acts as a hold-off flag: it stays high while the block is still working on the last byte, and the host waits for it to drop before it starts another byte. Host clock and data are synchronised into the system clock domain, and clock edges are detected there.

After reset the block first runs a self-test phase. For the whole phase the return line stays high, and display memory is initialised from two strap inputs. When the line drops, the block is ready. The response it shifts out during the first command byte is a fixed code that reports the self-test outcome. Each later byte is handed to the command logic as a one-cycle strobe, and the response for the following transfer is captured when processing ends. Display memory covers 10 grids by 14 segments and is given as a flat vector plus a brightness flag.

Top module: `vfd_link_slave`

## Requirements
- R1: From reset, `host_sdo` stays high for the self-test phase of about `ST_CYC` system cycles. It then falls low, which marks the block as ready.
- R2: While the block is ready, `host_sdi` is sampled on every rising edge of `host_sck`, most significant bit first. After the eighth rising edge, `cmd_valid` pulses for one cycle and `cmd_byte` holds the full byte.
- R3: While the block is ready, each falling edge of `host_sck` puts the next response bit on `host_sdo`, most significant bit first. The bit is therefore stable when the host samples it at the following rising edge.
- R4: The response shifted out during the first byte after reset is 8'h01 if `selftest_pass` was high at the end of self-test, and 8'h55 if it was low.
- R5: After the eighth rising edge, `host_sdo` goes high and stays high for about `PROC_CYC` cycles, then falls low. At that moment `resp_byte` is captured, and it becomes the response of the next transfer.
- R6: Host clock edges that arrive while `host_sdo` is high as busy are ignored. They raise no `cmd_valid`, keep the line high, and do not disturb the next byte.
- R7: The strap pair {`strap_test_n`, `strap_en_n`} selects the initial display. Segment index g*14+a means grid g, anode a.
  - 2'b10: every segment lit, `disp_full`=1.
  - 2'b11: every segment lit, `disp_full`=0.
  - 2'b00: checkerboard, with a segment lit when g+a is even, `disp_full`=1.
  - 2'b01: the complement of that checkerboard, `disp_full`=1.
- R8: The straps are followed only during self-test. Changes to them after the block is ready leave `disp_seg` and `disp_full` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sck | input | 1 | Host serial clock, idles high |
| host_sdi | input | 1 | Command data from host |
| host_sdo | output | 1 | Response data / busy flag to host |
| strap_test_n | input | 1 | Active-low test strap |
| strap_en_n | input | 1 | Active-low enable strap |
| selftest_pass | input | 1 | Self-test outcome, sampled at end of self-test |
| resp_byte | input | 8 | Response for the next transfer |
| cmd_valid | output | 1 | One-cycle strobe per received byte |
| cmd_byte | output | 8 | Last received command byte |
| disp_seg | output | 140 | Display memory, grid-major |
| disp_full | output | 1 | Full-brightness flag |

## Verification
A bit counter that drifts out of step with the host shows up within the same byte. Either `cmd_byte` comes out rotated, or `cmd_valid` arrives one edge early or late, and the busy rise on `host_sdo` moves with it. A stuck state or a wrong timer load makes the busy window on `host_sdo` too short or too long, and this is visible within `PROC_CYC` cycles of the last rising edge. A wrong response load is caught on the very next transfer, because the bits the host collects no longer match the self-test code or the captured `resp_byte`.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CODE_PASS = 8'h01;
  localparam logic [BYTE_W-1:0] CODE_FAIL = 8'h55;

  typedef enum logic [1:0] {
    LS_TEST  = 2'd0,
    LS_READY = 2'd1,
    LS_BUSY  = 2'd2
  } lnk_state_e;
endpackage

// File: rtl/lnk_sync_edge.sv
module lnk_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic sdi_in,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);
  logic [STAGES-1:0] sck_q, sck_d;
  logic [STAGES-1:0] sdi_q, sdi_d;
  logic              prev_q;

  // shift chains, built per stage
  genvar k;
  generate
    for (k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign sck_d[k] = sck_in;
        assign sdi_d[k] = sdi_in;
      end else begin : g_next
        assign sck_d[k] = sck_q[k-1];
        assign sdi_d[k] = sdi_q[k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= {STAGES{1'b1}};
      sdi_q  <= '0;
      prev_q <= 1'b1;
    end else begin
      sck_q  <= sck_d;
      sdi_q  <= sdi_d;
      prev_q <= sck_q[STAGES-1];
    end
  end

  assign sck_rise = sck_q[STAGES-1] & ~prev_q;
  assign sck_fall = ~sck_q[STAGES-1] & prev_q;
  assign sdi_s    = sdi_q[STAGES-1];
endmodule

// File: rtl/lnk_byte_shift.sv
module lnk_byte_shift
  import lnk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              sdi,
  input  logic              tx_load,
  input  logic [BYTE_W-1:0] tx_val,
  output logic              rx_last,
  output logic [BYTE_W-1:0] rx_word,
  output logic              tx_msb
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [BYTE_W-1:0] rx_q, rx_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    rx_d  = rx_q;
    tx_d  = tx_q;
    cnt_d = cnt_q;
    if (tx_load) begin
      tx_d  = tx_val;
      cnt_d = '0;
    end else begin
      if (rx_en) begin
        rx_d  = {rx_q[BYTE_W-2:0], sdi};
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
      if (tx_en) tx_d = {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
    end else begin
      rx_q  <= rx_d;
      tx_q  <= tx_d;
      cnt_q <= cnt_d;
    end
  end

  assign rx_last = rx_en && (cnt_q == LAST);
  assign rx_word = {rx_q[BYTE_W-2:0], sdi};
  assign tx_msb  = tx_q[BYTE_W-1];

  AST_LOAD_TAKES_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (tx_q == $past(tx_val))) else $error("tx load lost"); // R4
endmodule

// File: rtl/lnk_init_pattern.sv
module lnk_init_pattern #(
  parameter int GRIDS = 10,
  parameter int SEGS  = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  test_n,
  input  logic                  en_n,
  output logic [GRIDS*SEGS-1:0] seg_q,
  output logic                  full_q
);
  localparam int NSEG = GRIDS * SEGS;

  logic [NSEG-1:0] chk;
  logic [NSEG-1:0] seg_d;
  logic            full_d;

  genvar g, a;
  generate
    for (g = 0; g < GRIDS; g++) begin : g_grid
      for (a = 0; a < SEGS; a++) begin : g_seg
        assign chk[g*SEGS+a] = (((g + a) % 2) == 0) ? 1'b1 : 1'b0;
      end
    end
  endgenerate

  always_comb begin
    seg_d  = seg_q;
    full_d = full_q;
    if (load) begin
      case ({test_n, en_n})
        2'b10:   begin seg_d = '1;   full_d = 1'b1; end
        2'b11:   begin seg_d = '1;   full_d = 1'b0; end
        2'b00:   begin seg_d = chk;  full_d = 1'b1; end
        default: begin seg_d = ~chk; full_d = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= '0;
      full_q <= 1'b0;
    end else begin
      seg_q  <= seg_d;
      full_q <= full_d;
    end
  end

  AST_PATTERN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(seg_q) && $stable(full_q))) else $error("pattern moved"); // R8
endmodule

// File: rtl/vfd_link_slave.sv
module vfd_link_slave
  import lnk_pkg::*;
#(
  parameter int ST_CYC      = 4096,
  parameter int PROC_CYC    = 64,
  parameter int SYNC_STAGES = 2,
  parameter int GRIDS       = 10,
  parameter int SEGS        = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_sck,
  input  logic                  host_sdi,
  output logic                  host_sdo,
  input  logic                  strap_test_n,
  input  logic                  strap_en_n,
  input  logic                  selftest_pass,
  input  logic [BYTE_W-1:0]     resp_byte,
  output logic                  cmd_valid,
  output logic [BYTE_W-1:0]     cmd_byte,
  output logic [GRIDS*SEGS-1:0] disp_seg,
  output logic                  disp_full
);
  localparam int TMAX = (ST_CYC > PROC_CYC) ? ST_CYC : PROC_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_ST   = TW'(ST_CYC - 1);
  localparam logic [TW-1:0] T_PROC = TW'(PROC_CYC - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rs_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rs_n = rs_q[1];

  logic sck_rise, sck_fall, sdi_s;
  lnk_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rs_n), .sck_in(host_sck), .sdi_in(host_sdi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s)
  );

  lnk_state_e        st_q, st_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              sdo_q, sdo_d;
  logic              vld_q, vld_d;
  logic [BYTE_W-1:0] cmd_q, cmd_d;
  logic              rx_en, tx_en, tx_load, rx_last, tx_msb;
  logic [BYTE_W-1:0] tx_val, rx_word;

  assign rx_en = sck_rise && (st_q == LS_READY);
  assign tx_en = sck_fall && (st_q == LS_READY);

  lnk_byte_shift u_shift (
    .clk(clk), .rst_n(rs_n), .rx_en(rx_en), .tx_en(tx_en), .sdi(sdi_s),
    .tx_load(tx_load), .tx_val(tx_val), .rx_last(rx_last),
    .rx_word(rx_word), .tx_msb(tx_msb)
  );

  lnk_init_pattern #(.GRIDS(GRIDS), .SEGS(SEGS)) u_pat (
    .clk(clk), .rst_n(rs_n), .load(st_q == LS_TEST),
    .test_n(strap_test_n), .en_n(strap_en_n),
    .seg_q(disp_seg), .full_q(disp_full)
  );

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    sdo_d   = sdo_q;
    vld_d   = 1'b0;
    cmd_d   = cmd_q;
    tx_load = 1'b0;
    tx_val  = resp_byte;
    case (st_q)
      LS_TEST: begin
        tmr_d = tmr_q - 1'b1;
        if (tmr_q == '0) begin
          st_d    = LS_READY;
          sdo_d   = 1'b0;
          tx_load = 1'b1;
          tx_val  = selftest_pass ? CODE_PASS : CODE_FAIL;
        end
      end
      LS_READY: begin
        if (rx_last) begin
          st_d  = LS_BUSY;
          tmr_d = T_PROC;
          sdo_d = 1'b1;
          vld_d = 1'b1;
          cmd_d = rx_word;
        end else if (tx_en) begin
          sdo_d = tx_msb;
        end
      end
      default: begin
        tmr_d = tmr_q - 1'b1;
        if (tmr_q == '0) begin
          st_d    = LS_READY;
          sdo_d   = 1'b0;
          tx_load = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q  <= LS_TEST;
      tmr_q <= T_ST;
      sdo_q <= 1'b1;
      vld_q <= 1'b0;
      cmd_q <= '0;
    end else begin
      st_q  <= st_d;
      tmr_q <= tmr_d;
      sdo_q <= sdo_d;
      vld_q <= vld_d;
      cmd_q <= cmd_d;
    end
  end

  assign host_sdo  = sdo_q;
  assign cmd_valid = vld_q;
  assign cmd_byte  = cmd_q;

  AST_BUSY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rs_n)
    (st_q != LS_READY) |-> host_sdo) else $error("busy not shown"); // R5
  AST_READY_DROPS_LINE: assert property (@(posedge clk) disable iff (!rs_n)
    (st_q == LS_TEST && tmr_q == '0) |=> (!host_sdo && st_q == LS_READY)) else $error("no ready"); // R1
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rs_n)
    cmd_valid |=> !cmd_valid) else $error("long strobe"); // R2
  AST_VALID_ENTERS_BUSY: assert property (@(posedge clk) disable iff (!rs_n)
    cmd_valid |-> (st_q == LS_BUSY)) else $error("strobe outside busy"); // R6
endmodule

// File: tb/vfd_link_slave_bench.sv
module vfd_link_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ST  = 40;
  localparam int PR  = 20;
  localparam int HB  = 8;
  localparam int NS  = 140;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sck = 1'b1, host_sdi = 1'b0;
  logic strap_test_n = 1'b1, strap_en_n = 1'b0, selftest_pass = 1'b1;
  logic [7:0] resp_byte = 8'h00;
  logic host_sdo, cmd_valid, disp_full;
  logic [7:0] cmd_byte;
  logic [NS-1:0] disp_seg;

  int n_tests = 0, n_fail = 0, n_valid = 0;
  logic [7:0] last_cmd = 8'h00;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vfd_link_slave #(.ST_CYC(ST), .PROC_CYC(PR)) u_vfd_link_slave (
    .clk(clk), .rst_n(rst_n), .host_sck(host_sck), .host_sdi(host_sdi),
    .host_sdo(host_sdo), .strap_test_n(strap_test_n), .strap_en_n(strap_en_n),
    .selftest_pass(selftest_pass), .resp_byte(resp_byte),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .disp_seg(disp_seg), .disp_full(disp_full)
  );

  always @(negedge clk) if (rst_n && cmd_valid) begin
    n_valid++;
    last_cmd = cmd_byte;
  end

  task automatic check(input bit ok, input string req, input logic [159:0] act, input logic [159:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NS-1:0] exp_seg(input logic tn, input logic en);
    logic [NS-1:0] v;
    for (int g = 0; g < 10; g++)
      for (int a = 0; a < 14; a++)
        v[g*14+a] = ((g + a) % 2) == 0;
    case ({tn, en})
      2'b10, 2'b11: return '1;
      2'b00:        return v;
      default:      return ~v;
    endcase
  endfunction

  function automatic logic exp_full(input logic tn, input logic en);
    return !(tn && en);
  endfunction

  logic [7:0] exp_resp;

  task automatic do_reset(input logic tn, input logic en, input logic pass);
    int cnt;
    @(negedge clk);
    rst_n = 1'b0; host_sck = 1'b1;
    strap_test_n = tn; strap_en_n = en; selftest_pass = pass;
    repeat (3) @(negedge clk);
    check(host_sdo == 1'b1, "R1 busy in reset", 160'(host_sdo), 160'(1));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(host_sdo == 1'b1, "R1 busy in self-test", 160'(host_sdo), 160'(1));
    cnt = 5;
    while (host_sdo && cnt < ST + 20) begin @(negedge clk); cnt++; end
    check(cnt >= ST && cnt <= ST + 6, "R1 self-test length", 160'(cnt), 160'(ST));
    exp_resp = pass ? 8'h01 : 8'h55;
    check(disp_seg == exp_seg(tn, en), "R7 pattern", 160'(disp_seg), 160'(exp_seg(tn, en)));
    check(disp_full == exp_full(tn, en), "R7 brightness", 160'(disp_full), 160'(exp_full(tn, en)));
  endtask

  task automatic xfer(input logic [7:0] tx, input bit inject);
    logic [7:0] rx;
    int cnt, v0;
    v0 = n_valid;
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); host_sck = 1'b0; host_sdi = tx[i];
      repeat (HB) @(negedge clk);
      rx[i] = host_sdo;
      host_sck = 1'b1;
      repeat (HB - 1) @(negedge clk);
    end
    cnt = HB - 1;
    check(host_sdo == 1'b1, "R5 busy after byte", 160'(host_sdo), 160'(1));
    if (inject) begin
      host_sck = 1'b0; host_sdi = ~host_sdi;
      repeat (3) @(negedge clk);
      host_sck = 1'b1;
      repeat (4) @(negedge clk);
      cnt += 7;
      check(host_sdo == 1'b1, "R6 line held during busy edges", 160'(host_sdo), 160'(1));
    end
    check(rx == exp_resp, "R3/R4 response bits", 160'(rx), 160'(exp_resp));
    check(n_valid == v0 + 1, "R2 one strobe per byte", 160'(n_valid - v0), 160'(1));
    check(last_cmd == tx, "R2 received byte", 160'(last_cmd), 160'(tx));
    while (host_sdo && cnt < PR + 40) begin @(negedge clk); cnt++; end
    check(cnt >= PR - 2 && cnt <= PR + 6, "R5 busy length", 160'(cnt), 160'(PR));
    check(n_valid == v0 + 1, "R6 no strobe from busy edges", 160'(n_valid - v0), 160'(1));
    exp_resp = resp_byte;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int m = 0; m < 4; m++) begin
      logic tn, en, pass;
      tn = m[1]; en = m[0];
      pass = (m == 2) ? 1'b1 : ((m == 1) ? 1'b0 : 1'($urandom % 2));
      do_reset(tn, en, pass);
      for (int b = 0; b < 6; b++) begin
        logic [7:0] tx;
        case (b)
          0: tx = 8'h00;
          1: tx = 8'hFF;
          2: tx = 8'h80;
          default: tx = 8'($urandom);
        endcase
        resp_byte = (b == 1) ? 8'h01 : 8'($urandom);
        xfer(tx, b == 3);
      end
      strap_test_n = ~tn; strap_en_n = ~en;
      repeat (10) @(negedge clk);
      check(disp_seg == exp_seg(tn, en), "R8 straps ignored when ready", 160'(disp_seg), 160'(exp_seg(tn, en)));
      check(disp_full == exp_full(tn, en), "R8 brightness held", 160'(disp_full), 160'(exp_full(tn, en)));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule